// File: doc/BRIEF.md
# Pipelined Read Output Deselect Control

This block owns the output side of a synchronous pipelined SRAM's read path. On every rising clock edge it captures three chip-select inputs and a write strobe, and classifies the cycle as a read, a write or a deselect. A read captured on one edge takes the array data presented in the following cycle into an output register on the next edge. The data bus is driven from that point, as long as the asynchronous output enable is low.

A static mode input sets how far a deselect travels down the pipeline before it switches the bus off. With dual-cycle deselect selected, a deselect moves exactly as far as a read does. The data of a read just before the deselect therefore still appears, and the bus turns off one edge after the deselect was captured. With single-cycle deselect selected, a deselect acts one stage earlier. It switches the bus off on the same edge that captures it. A write always switches the bus off on its capture edge, in both modes, so the part never drives while write data is arriving. Board designs normally tie the mode input high, which selects single-cycle deselect.

The memory array, the burst counter and the write data path sit outside this block. Array read data arrives as a plain input, and the tri-state pins are modelled as a data vector plus a drive-enable output.

Top module: `odc_read_out`

## Requirements
- R1: While reset is held and after its release, before any read, `dq_drive` is 0 and `dq_out` is all zeros.
- R2: A cycle counts as selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A selected cycle with `wr_en`=1 is a write, a selected cycle with `wr_en`=0 is a read, and every other input combination is a deselect.
- R3: A read captured at edge k loads `rd_data`, as sampled at edge k+1, into the output register. After edge k+1 `dq_drive` is 1 and `dq_out` equals that data, unless R4, R5, R6 or R7 turn the bus off.
- R4: With `mode_single`=0, a deselect captured at edge k leaves the data of a read captured at edge k-1 driven after edge k. The bus turns off after edge k+1.
- R5: With `mode_single`=1, a deselect captured at edge k turns the bus off right after edge k, even when a read was captured at edge k-1.
- R6: In either mode, a write captured at edge k turns the bus off right after edge k.
- R7: `out_en_n`=1 forces `dq_drive` to 0 at once, with no clock edge needed. When it returns to 0, the registered drive state reappears at once.
- R8: Whenever `dq_drive` is 0, `dq_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_single | input | 1 | 1 selects single-cycle deselect, 0 selects dual-cycle deselect |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_en | input | 1 | Write strobe for a selected cycle |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rd_data | input | DATA_W | Read data from the array |
| dq_out | output | DATA_W | Data bus value, zero when not driven |
| dq_drive | output | 1 | Tri-state drive enable for the data bus |

## Verification
The hardest corner case is a read followed at once by a deselect, tried in both modes. A design that mixes up the modes would drop the final read word in dual-cycle mode, or leave the bus on for an extra cycle in single-cycle mode. A read followed at once by a write must lose its output in both modes; a design that handles writes like deselects would drive into incoming write data in dual-cycle mode. The bench walks all eight chip-select combinations, because a wrong polarity would either let a partly selected part drive or silence a selected one. It also toggles the output enable between clock edges to catch any registered path in that gate.

// File: rtl/odc_pkg.sv
package odc_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } odc_cmd_e;

endpackage

// File: rtl/odc_cmd_decode.sv
module odc_cmd_decode
    import odc_pkg::*;
(
    input  logic     sel_a_n,
    input  logic     sel_b,
    input  logic     sel_c_n,
    input  logic     wr_en,
    output odc_cmd_e cmd
);

    logic chip_sel;

    always_comb begin
        chip_sel = ~sel_a_n & sel_b & ~sel_c_n;
        if (!chip_sel) begin
            cmd = CMD_IDLE;
        end else if (wr_en) begin
            cmd = CMD_WRITE;
        end else begin
            cmd = CMD_READ;
        end
    end

endmodule

// File: rtl/odc_out_stage.sv
module odc_out_stage
    import odc_pkg::*;
#(
    parameter int DATA_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_single,
    input  odc_cmd_e          cmd_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic              drive_reg,
    output logic [DATA_W-1:0] data_reg
);

    typedef struct packed {
        odc_cmd_e          cap;
        logic              drv;
        logic [DATA_W-1:0] dat;
    } stage_t;

    stage_t st_d, st_q;
    logic   read_held;
    logic   cut_now;

    always_comb begin
        st_d      = st_q;
        read_held = (st_q.cap == CMD_READ);
        if (mode_single) begin
            cut_now = (cmd_in != CMD_READ);
        end else begin
            cut_now = (cmd_in == CMD_WRITE);
        end
        st_d.cap = cmd_in;
        st_d.drv = read_held & ~cut_now;
        if (read_held) begin
            st_d.dat = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cap <= CMD_IDLE;
            st_q.drv <= 1'b0;
            st_q.dat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_reg = st_q.drv;
    assign data_reg  = st_q.dat;

endmodule

// File: rtl/odc_read_out.sv
module odc_read_out
    import odc_pkg::*;
#(
    parameter int DATA_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_single,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_en,
    input  logic              out_en_n,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);

    odc_cmd_e          cmd;
    logic              drive_reg;
    logic [DATA_W-1:0] data_reg;

    odc_cmd_decode i_dec (
        .sel_a_n (sel_a_n),
        .sel_b   (sel_b),
        .sel_c_n (sel_c_n),
        .wr_en   (wr_en),
        .cmd     (cmd)
    );

    odc_out_stage #(.DATA_W(DATA_W)) i_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_single (mode_single),
        .cmd_in      (cmd),
        .rd_data     (rd_data),
        .drive_reg   (drive_reg),
        .data_reg    (data_reg)
    );

    // the output enable bypasses every register
    assign dq_drive = drive_reg & ~out_en_n;
    assign dq_out   = dq_drive ? data_reg : '0;

endmodule

// File: rtl/odc_read_out_chk.sv
module odc_read_out_chk #(
    parameter int DATA_W = 72
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_single,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              wr_en,
    input logic              out_en_n,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_drive
);

    logic picked;
    logic rd_now;
    logic rd_prev;

    assign picked = ~sel_a_n & sel_b & ~sel_c_n;
    assign rd_now = picked & ~wr_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
        end else begin
            rd_prev <= rd_now;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !dq_drive);

    // R3
    a_r3_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_prev && rd_now) |=> (dq_drive || out_en_n));

    // R4
    a_r4_dual_keeps_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_single && rd_prev && !picked) |=> (dq_drive || out_en_n));

    // R5 and R2
    a_r5_single_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_single && !picked) |=> !dq_drive);

    // R6
    a_r6_write_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (picked && wr_en) |=> !dq_drive);

    // R7
    a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dq_drive);

    // R8
    a_r8_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_drive |-> (dq_out == '0));

endmodule

bind odc_read_out odc_read_out_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_odc_read_out.sv
module test_odc_read_out;

    localparam int W = 72;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         mode_single;
    logic         sel_a_n, sel_b, sel_c_n, wr_en, out_en_n;
    logic [W-1:0] rd_data;
    logic [W-1:0] dq_out;
    logic         dq_drive;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench reference state, built from the requirements
    int           m_prev;   // 0 idle, 1 read, 2 write
    bit           m_drv;
    logic [W-1:0] m_dat;
    string        why;

    always #5 clk = ~clk;

    odc_read_out #(.DATA_W(W)) i_odc_read_out (.*);

    function automatic int classify(logic a_n, logic b, logic c_n, logic w);
        if (!(!a_n && b && !c_n)) return 0;
        return w ? 2 : 1;
    endfunction

    function automatic logic [W-1:0] rnd_word();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check(string tag);
        bit           e_drv;
        logic [W-1:0] e_dq;
        e_drv = m_drv && !out_en_n;
        e_dq  = e_drv ? m_dat : '0;
        checks++;
        if (dq_drive !== e_drv) begin
            errors++;
            $display("FAIL %s dq_drive actual %0b expected %0b", tag, dq_drive, e_drv);
        end
        checks++;
        if (dq_out !== e_dq) begin
            errors++;
            $display("FAIL %s dq_out actual %h expected %h", e_drv ? tag : "R8", dq_out, e_dq);
        end
    endtask

    function automatic string auto_tag();
        if (out_en_n) return "R7";
        return why;
    endfunction

    // one clock: check previous result, drive new inputs, re-check the async gate, take the edge
    task automatic step(logic a_n, logic b, logic c_n, logic w, logic oen, logic [W-1:0] d);
        int c;
        @(negedge clk);
        check(auto_tag());
        sel_a_n = a_n; sel_b = b; sel_c_n = c_n; wr_en = w;
        out_en_n = oen; rd_data = d;
        #1;
        check(out_en_n ? "R7" : auto_tag());
        @(posedge clk);
        c = classify(a_n, b, c_n, w);
        why = "R3";
        if (m_prev == 1 && c == 2) why = "R6";
        else if (m_prev == 1 && c == 0 && mode_single) why = "R5";
        else if (m_prev == 1 && c == 0) why = "R4";
        else if (m_prev != 1) why = "R2";
        if (mode_single) m_drv = (m_prev == 1) && (c == 1);
        else             m_drv = (m_prev == 1) && (c != 2);
        if (m_prev == 1) m_dat = d;
        m_prev = c;
    endtask

    task automatic do_reset(logic mode);
        mode_single = mode;
        rst_n = 1'b0;
        sel_a_n = 1; sel_b = 0; sel_c_n = 1; wr_en = 0; out_en_n = 0; rd_data = '0;
        m_prev = 0; m_drv = 0; m_dat = '0; why = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
    endtask

    task automatic rd(logic [W-1:0] d);  step(0, 1, 0, 0, 0, d); endtask
    task automatic wrc(logic [W-1:0] d); step(0, 1, 0, 1, 0, d); endtask
    task automatic ds(logic [W-1:0] d);  step(1, 1, 0, 0, 0, d); endtask

    task automatic directed(logic mode);
        do_reset(mode);
        ds(rnd_word());
        check("R1");
        // R2: every select combination, between reads
        for (int k = 0; k < 8; k++) begin
            rd(rnd_word());
            step(k[2], k[1], k[0], 1'b0, 1'b0, rnd_word());
            rd(rnd_word());
            rd(rnd_word());
        end
        // R4 / R5: read burst ended by a deselect
        rd(rnd_word()); rd(rnd_word()); rd(rnd_word());
        ds(rnd_word()); ds(rnd_word()); ds(rnd_word());
        // R6: read burst ended by a write
        rd(rnd_word()); rd(rnd_word()); wrc(rnd_word());
        wrc(rnd_word()); rd(rnd_word()); rd(rnd_word());
        // R7: output enable pulsed mid-burst
        rd(rnd_word()); step(0, 1, 0, 0, 1, rnd_word());
        step(0, 1, 0, 0, 0, rnd_word()); rd(rnd_word());
        ds(rnd_word()); ds(rnd_word());
    endtask

    task automatic random_run(logic mode, int n);
        do_reset(mode);
        for (int i = 0; i < n; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 6)
                step(0, 1, 0, ($urandom_range(0, 4) == 0), ($urandom_range(0, 7) == 0), rnd_word());
            else
                step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 1), ($urandom_range(0, 7) == 0), rnd_word());
        end
    endtask

    initial begin
        void'($urandom(32'h1d5c_0a37));
        directed(1'b1);
        directed(1'b0);
        random_run(1'b1, 3000);
        random_run(1'b0, 3000);
        @(negedge clk);
        check(auto_tag());
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule